// File: doc/BRIEF.md
# Coin Vending Controller

This block collects coins reported by a coin sensor and asserts a release strobe once at least fifteen cents has been paid. Each clock cycle the sensor can report a five-cent coin or a ten-cent coin. The controller keeps a saturating credit level of 0, 5, 10 or 15-plus cents. It gives no change, so a second dime on top of ten cents still releases only one item. The credit clears only when reset is applied.

A build-time parameter selects the output style. In state-decoded style, the release line depends only on the stored credit. In input-decoded style, the release line also rises during the cycle in which the coin that completes the price is presented. In that style the release comes one cycle earlier, but it then depends on the sensor inputs.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the credit to zero cents at the next rising clock edge, and after that edge the release output is low. While reset is asserted and before that edge, the release output keeps its previous value.
- R2: A cycle with only the five-cent input high adds one step (five cents) to the credit, and the new credit takes effect at the next clock edge.
- R3: A cycle with the ten-cent input high adds two steps (ten cents) to the credit, and the new credit takes effect at the next clock edge.
- R4: A cycle with no coin input high leaves the credit unchanged.
- R5: The credit saturates at fifteen-plus cents. Once it is there, it stays there whatever coins arrive, until reset.
- R6: When both coin inputs are high in the same cycle, the cycle counts as a single ten-cent coin.
- R7: In state-decoded mode (MEALY_OUT = 0), the release output is high exactly while the stored credit is fifteen-plus cents.
- R8: In input-decoded mode (MEALY_OUT = 1), the release output is high in three cases: while the credit is fifteen-plus; while the credit is ten cents and either coin input is high; and while the credit is five cents and the ten-cent input is high.

Internal credit encoding: 00 for zero, 01 for five, 10 for ten and 11 for fifteen-plus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| nickel_i | input | 1 | Five-cent coin pulse, one cycle per coin |
| dime_i | input | 1 | Ten-cent coin pulse, one cycle per coin |
| open_o | output | 1 | Item release strobe |

## Verification
The bench builds two copies of the block side by side, one with MEALY_OUT = 0 and one with MEALY_OUT = 1, and drives both with the same coin stream. Because the two copies must always hold the same credit, the state-decoded copy shows the credit reached after each coin. The input-decoded copy, sampled while a coin is still presented, shows the early release in the five-cent and ten-cent credit states. Together they cover the step sizes, the saturation, the simultaneous-coin rule and the exact edge at which reset takes effect.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // Credit width is fixed by the four-level encoding.
  localparam int CREDIT_W = 2;
  localparam int SUM_W    = CREDIT_W + 1;

  typedef enum logic [CREDIT_W-1:0] {
    CR_ZERO = 2'b00,
    CR_FIVE = 2'b01,
    CR_TEN  = 2'b10,
    CR_FULL = 2'b11
  } credit_t;

  // Steps added by one sensor cycle; a dime wins over a nickel.
  function automatic logic [CREDIT_W-1:0] coin_steps(input logic nk, input logic dm);
    if (dm)      return CREDIT_W'(2);
    else if (nk) return CREDIT_W'(1);
    else         return '0;
  endfunction
endpackage

// File: rtl/vend_next.sv
module vend_next
  import vend_pkg::*;
(
  input  credit_t cur_i,
  input  logic    nickel_i,
  input  logic    dime_i,
  output credit_t nxt_o
);
  localparam logic [SUM_W-1:0] TOP = SUM_W'(CR_FULL);

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(cur_i) + SUM_W'(coin_steps(nickel_i, dime_i));
    if (cur_i == CR_FULL)  nxt_o = CR_FULL;
    else if (sum >= TOP)   nxt_o = CR_FULL;
    else                   nxt_o = credit_t'(sum[CREDIT_W-1:0]);
  end
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  credit_t d_i,
  output credit_t q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= CR_ZERO;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/vend_out.sv
module vend_out
  import vend_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0
) (
  input  credit_t cur_i,
  input  credit_t nxt_i,
  output logic    open_o
);
  generate
    if (MEALY_OUT) begin : g_mealy
      // Release as soon as the completing coin is seen.
      assign open_o = (cur_i == CR_FULL) || (nxt_i == CR_FULL);
    end else begin : g_moore
      assign open_o = (cur_i == CR_FULL);
    end
  endgenerate
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import vend_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic nickel_i,
  input  logic dime_i,
  output logic open_o
);
  credit_t state_q;
  credit_t state_d;

  vend_next u_next (
    .cur_i    (state_q),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .nxt_o    (state_d)
  );

  vend_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .d_i (state_d),
    .q_o (state_q)
  );

  vend_out #(.MEALY_OUT(MEALY_OUT)) u_out (
    .cur_i  (state_q),
    .nxt_i  (state_d),
    .open_o (open_o)
  );
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
  import vend_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0
) (
  input logic    clk,
  input logic    rst,
  input logic    nickel_i,
  input logic    dime_i,
  input logic    open_o,
  input credit_t state_q
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> state_q == CR_ZERO);

  // R2
  nickel_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == CR_ZERO && nickel_i && !dime_i) |=> state_q == CR_FIVE);

  // R3
  dime_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == CR_FIVE && dime_i) |=> state_q == CR_FULL);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!nickel_i && !dime_i) |=> $stable(state_q));

  // R5
  full_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == CR_FULL |=> state_q == CR_FULL);

  // R6
  both_as_dime_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == CR_ZERO && nickel_i && dime_i) |=> state_q == CR_TEN);

  // R7
  moore_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!MEALY_OUT && !$past(rst) && $rose(open_o)) |-> $past(nickel_i || dime_i));

  // R8
  mealy_early_chk: assert property (@(posedge clk) disable iff (rst)
    (MEALY_OUT && state_q == CR_FIVE && dime_i) |-> open_o);
endmodule

bind coin_vend_ctrl vend_ctrl_chk #(.MEALY_OUT(MEALY_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .nickel_i (nickel_i),
  .dime_i   (dime_i),
  .open_o   (open_o),
  .state_q  (state_q)
);

// File: tb/coin_vend_ctrl_bench.sv
`timescale 1ns/1ps
module coin_vend_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nk  = 1'b0;
  logic dm  = 1'b0;
  logic open_moore;
  logic open_mealy;
  logic last_mealy;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #5 clk = ~clk;

  coin_vend_ctrl #(.MEALY_OUT(1'b0)) u_coin_vend_ctrl (
    .clk(clk), .rst(rst), .nickel_i(nk), .dime_i(dm), .open_o(open_moore));

  coin_vend_ctrl #(.MEALY_OUT(1'b1)) u_coin_vend_ctrl_mealy (
    .clk(clk), .rst(rst), .nickel_i(nk), .dime_i(dm), .open_o(open_mealy));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with coins cleared.
  task automatic coin(input logic n, input logic d);
    nk = n; dm = d;
    #1 last_mealy = open_mealy;
    @(negedge clk);
    nk = 0; dm = 0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 moore after reset", open_moore, 1'b0);
    check("R1 mealy after reset", open_mealy, 1'b0);
  endtask

  task automatic t_nickels();
    do_reset();
    coin(1, 0);
    check("R2 moore at five", open_moore, 1'b0);
    check("R8 mealy zero+nickel", last_mealy, 1'b0);
    coin(1, 0);
    check("R2 moore at ten", open_moore, 1'b0);
    check("R8 mealy five+nickel", last_mealy, 1'b0);
    coin(1, 0);
    check("R8 mealy ten+nickel early", last_mealy, 1'b1);
    check("R2 R7 moore at full", open_moore, 1'b1);
  endtask

  task automatic t_hold();
    do_reset();
    coin(1, 0);
    repeat (5) @(negedge clk);
    #1;
    check("R4 moore idle at five", open_moore, 1'b0);
    coin(0, 1);
    check("R8 mealy five+dime early", last_mealy, 1'b1);
    check("R3 moore five+dime full", open_moore, 1'b1);
  endtask

  task automatic t_dimes();
    do_reset();
    coin(0, 1);
    check("R3 moore at ten", open_moore, 1'b0);
    check("R8 mealy zero+dime", last_mealy, 1'b0);
    check("R8 mealy ten idle", open_mealy, 1'b0);
    coin(0, 1);
    check("R8 mealy ten+dime early", last_mealy, 1'b1);
    check("R7 moore full", open_moore, 1'b1);
    coin(0, 1);
    coin(1, 0);
    coin(1, 1);
    repeat (3) @(negedge clk);
    #1;
    check("R5 moore stays full", open_moore, 1'b1);
    check("R5 mealy stays full", open_mealy, 1'b1);
    // R1: reset is synchronous, so open holds until the edge.
    rst = 1;
    #1;
    check("R1 open held before edge", open_moore, 1'b1);
    @(negedge clk);
    rst = 0;
    #1;
    check("R1 moore cleared after edge", open_moore, 1'b0);
    check("R1 mealy cleared after edge", open_mealy, 1'b0);
  endtask

  task automatic t_both();
    do_reset();
    coin(1, 1);
    check("R6 moore both at ten", open_moore, 1'b0);
    check("R6 mealy zero+both", last_mealy, 1'b0);
    coin(1, 0);
    check("R6 mealy ten+nickel early", last_mealy, 1'b1);
    check("R6 moore both counted as dime", open_moore, 1'b1);
    do_reset();
    coin(1, 0);
    coin(1, 1);
    check("R6 moore five+both full", open_moore, 1'b1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_nickels();
    t_hold();
    t_dimes();
    t_both();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule